// File: doc/BRIEF.md
# Multi-Mode Operand Address Resolver

This block turns an instruction's addressing mode and address field into the value that an accumulator would load. A request presents a 3-bit mode code, a 12-bit address field and a register selector with a one-cycle `start` pulse. The block then works out the effective address from the field, a small register bank, an index register and a base register. Depending on the mode, it reads an external single-port synchronous data memory zero, one or two times. When the result is ready, it raises `done` for one cycle together with the effective address and the operand.

All register contents are sampled in the cycle the request is accepted, so the surrounding core may change them while the resolution is running. The memory returns read data in the cycle after `memRdEn` is high. Any address sum wraps within the 12-bit address space. While a request is in progress, including the cycle in which `done` is high, the block accepts no new request.

Top module: `operand_resolver`

## Requirements
- R1: Mode 000 (immediate) gives operand = address field zero-extended and effective address 0. It makes no memory read, and `done` rises 1 cycle after the accepting clock edge.
- R2: Mode 001 (direct) gives effective address = address field and operand = memory word at that address. It makes exactly one read, and `done` rises 3 cycles after acceptance.
- R3: Mode 010 (register) gives operand = the register selected by `regSel` and effective address 0. It makes no memory read, and `done` comes after 1 cycle.
- R4: Mode 011 (indirect) reads the word at the address field and uses its low 12 bits as the effective address. It then reads the operand from that address: exactly two reads, with `done` after 5 cycles.
- R5: Mode 100 (register indirect) uses the low 12 bits of the selected register as the effective address. It makes one read for the operand, with `done` after 3 cycles.
- R6: Mode 101 (indexed) sets effective address = (address field + low 12 bits of the index register) mod 4096. It makes one read, with `done` after 3 cycles.
- R7: Mode 110 (based) sets effective address = (low 12 bits of the base register + address field) mod 4096. It makes one read, with `done` after 3 cycles.
- R8: Mode 111 (stack) gives operand = top-of-stack input and effective address 0. It makes no memory read, and `done` comes after 1 cycle.
- R9: `done` is high for exactly one cycle per accepted request. `effAddr` and `operand` are valid in that cycle.
- R10: A `start` that arrives while a request is in progress, up to and including its `done` cycle, is ignored. It causes no memory read and no extra `done`.
- R11: Register bank, index, base and top-of-stack values are sampled at the accepting edge. Changes after that edge do not alter the result.
- R12: During and right after reset, `done` and `memRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| mode | input | 3 | Addressing mode code |
| addrField | input | ADDR_W (12) | Address field of the instruction |
| regSel | input | SEL_W (2) | Register bank selector |
| regBank | input | NUM_REGS*DATA_W (64) | Flattened register bank, register 0 in the low bits |
| indexVal | input | DATA_W (16) | Index register contents |
| baseVal | input | DATA_W (16) | Base register contents |
| tosVal | input | DATA_W (16) | Top-of-stack entry |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | ADDR_W (12) | Memory read address |
| memRdData | input | DATA_W (16) | Memory read data, valid the cycle after memRdEn |
| done | output | 1 | One-cycle completion strobe |
| effAddr | output | ADDR_W (12) | Resolved effective address |
| operand | output | DATA_W (16) | Resolved operand value |

## Verification
Every mode is first tried with a directed request, with register, index and base contents chosen so that each mode gives a different effective address and operand. A wrong mode decode therefore shows up as a wrong value. Address fields near 0xFFF with large index and base values separate a wrapping 12-bit sum from one that carries into a wider address. The registers are scrambled right after acceptance, which shows whether the inputs are sampled at acceptance or later. Stray `start` pulses during busy cycles show whether a second request is wrongly accepted. Seeded random requests then cover all modes together, checking the latency and the number of memory reads against the mode.

// File: rtl/resolver_pkg.sv
package resolver_pkg;

  typedef enum logic [2:0] {
    MODE_IMM  = 3'b000,
    MODE_DIR  = 3'b001,
    MODE_REG  = 3'b010,
    MODE_IND  = 3'b011,
    MODE_RIND = 3'b100,
    MODE_IDX  = 3'b101,
    MODE_BASE = 3'b110,
    MODE_STK  = 3'b111
  } addrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture request and compute first address/operand
    logic capEa;  // take effective address from memory data
    logic capOp;  // take operand from memory data
  } dpCtrl_t;

  // number of memory reads each mode needs
  function automatic logic [1:0] accessCount(input addrMode_t m);
    case (m)
      MODE_IMM, MODE_REG, MODE_STK: accessCount = 2'd0;
      MODE_IND:                     accessCount = 2'd2;
      default:                      accessCount = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/resolver_ctrl.sv
module resolver_ctrl
  import resolver_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  addrMode_t mode,
  output dpCtrl_t   strobe,
  output logic      memRdEn,
  output logic      done,
  output logic      accept
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISS1, ST_CAP1, ST_ISS2, ST_CAP2, ST_FIN
  } ctrlState_t;

  ctrlState_t state, stateNext;
  logic       twoReads, twoReadsNext;

  always_comb begin
    stateNext    = state;
    twoReadsNext = twoReads;
    strobe       = '0;
    memRdEn      = 1'b0;
    done         = 1'b0;
    accept       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          accept       = 1'b1;
          strobe.load  = 1'b1;
          twoReadsNext = (accessCount(mode) == 2'd2);
          stateNext    = (accessCount(mode) == 2'd0) ? ST_FIN : ST_ISS1;
        end
      end
      ST_ISS1: begin
        memRdEn   = 1'b1;
        stateNext = ST_CAP1;
      end
      ST_CAP1: begin
        if (twoReads) begin
          strobe.capEa = 1'b1;
          stateNext    = ST_ISS2;
        end else begin
          strobe.capOp = 1'b1;
          stateNext    = ST_FIN;
        end
      end
      ST_ISS2: begin
        memRdEn   = 1'b1;
        stateNext = ST_CAP2;
      end
      ST_CAP2: begin
        strobe.capOp = 1'b1;
        stateNext    = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      twoReads <= 1'b0;
    end else begin
      state    <= stateNext;
      twoReads <= twoReadsNext;
    end
  end

  // R9: completion strobe lasts a single cycle
  p_done_pulse_r9 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1 R3 R8: register-only modes finish in the next cycle
  p_quick_finish_r1 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && accessCount(mode) == 2'd0) |=> done);

endmodule

// File: rtl/resolver_dp.sv
module resolver_dp
  import resolver_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    strobe,
  input  addrMode_t                  mode,
  input  logic [ADDR_W-1:0]          addrField,
  input  logic [SEL_W-1:0]           regSel,
  input  logic [NUM_REGS*DATA_W-1:0] regBank,
  input  logic [DATA_W-1:0]          indexVal,
  input  logic [DATA_W-1:0]          baseVal,
  input  logic [DATA_W-1:0]          tosVal,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [ADDR_W-1:0]          effAddr,
  output logic [DATA_W-1:0]          operand
);

  logic [DATA_W-1:0] regArr [NUM_REGS];
  logic [DATA_W-1:0] regWord;
  logic [ADDR_W-1:0] eaReg, eaLoad;
  logic [DATA_W-1:0] opReg, opLoad;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_regSplit
    assign regArr[i] = regBank[i*DATA_W +: DATA_W];
  end

  assign regWord = regArr[regSel];

  // first-step address and operand, chosen by mode
  always_comb begin
    eaLoad = '0;
    opLoad = '0;
    case (mode)
      MODE_IMM:  opLoad = DATA_W'(addrField);
      MODE_DIR:  eaLoad = addrField;
      MODE_REG:  opLoad = regWord;
      MODE_IND:  eaLoad = addrField;  // pointer first
      MODE_RIND: eaLoad = regWord[ADDR_W-1:0];
      MODE_IDX:  eaLoad = addrField + indexVal[ADDR_W-1:0];
      MODE_BASE: eaLoad = baseVal[ADDR_W-1:0] + addrField;
      MODE_STK:  opLoad = tosVal;
      default:   eaLoad = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaReg <= '0;
      opReg <= '0;
    end else begin
      if (strobe.load)       eaReg <= eaLoad;
      else if (strobe.capEa) eaReg <= memRdData[ADDR_W-1:0];
      if (strobe.load)       opReg <= opLoad;
      else if (strobe.capOp) opReg <= memRdData;
    end
  end

  assign memAddr = eaReg;
  assign effAddr = eaReg;
  assign operand = opReg;

endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
  import resolver_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [2:0]                 mode,
  input  logic [ADDR_W-1:0]          addrField,
  input  logic [SEL_W-1:0]           regSel,
  input  logic [NUM_REGS*DATA_W-1:0] regBank,
  input  logic [DATA_W-1:0]          indexVal,
  input  logic [DATA_W-1:0]          baseVal,
  input  logic [DATA_W-1:0]          tosVal,
  output logic                       memRdEn,
  output logic [ADDR_W-1:0]          memAddr,
  input  logic [DATA_W-1:0]          memRdData,
  output logic                       done,
  output logic [ADDR_W-1:0]          effAddr,
  output logic [DATA_W-1:0]          operand
);

  dpCtrl_t   strobe;
  addrMode_t modeIn;
  logic      accept;

  assign modeIn = addrMode_t'(mode);

  resolver_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mode    (modeIn),
    .strobe  (strobe),
    .memRdEn (memRdEn),
    .done    (done),
    .accept  (accept)
  );

  resolver_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode      (modeIn),
    .addrField (addrField),
    .regSel    (regSel),
    .regBank   (regBank),
    .indexVal  (indexVal),
    .baseVal   (baseVal),
    .tosVal    (tosVal),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .effAddr   (effAddr),
    .operand   (operand)
  );

  // bookkeeping for the checks below
  logic [1:0] readCnt;
  addrMode_t  modeSeen;
  logic       pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCnt  <= '0;
      modeSeen <= MODE_IMM;
      pending  <= 1'b0;
    end else begin
      if (accept) begin
        readCnt  <= '0;
        modeSeen <= modeIn;
      end else if (memRdEn && readCnt != 2'd3) begin
        readCnt <= readCnt + 2'd1;
      end
      if (accept)    pending <= 1'b1;
      else if (done) pending <= 1'b0;
    end
  end

  // R2 R4: memory read count matches the mode at completion
  p_access_budget_r2 : assert property (@(posedge clk) disable iff (!rstN)
    done |-> (readCnt == accessCount(modeSeen)));

  // R10: no acceptance while a request is outstanding
  p_accept_idle_r10 : assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !pending);

  // R10: each done belongs to an accepted request
  p_done_owned_r10 : assert property (@(posedge clk) disable iff (!rstN)
    done |-> pending);

  // R12: quiet outputs in the first cycle after reset
  p_reset_quiet_r12 : assert property (@(posedge clk)
    !rstN |=> (!done && !memRdEn));

endmodule

// File: tb/operand_resolver_test.sv
module operand_resolver_test;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int NREG   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        mode = '0;
  logic [ADDR_W-1:0] addrField = '0;
  logic [1:0]        regSel = '0;
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] indexVal = '0, baseVal = '0, tosVal = '0;
  logic              memRdEn, done;
  logic [ADDR_W-1:0] memAddr, effAddr;
  logic [DATA_W-1:0] memRdData = '0, operand;
  logic [NREG*DATA_W-1:0] regBank;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  assign regBank = {regs[3], regs[2], regs[1], regs[0]};

  always #5 clk = ~clk;

  operand_resolver uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .addrField(addrField),
    .regSel(regSel), .regBank(regBank), .indexVal(indexVal), .baseVal(baseVal),
    .tosVal(tosVal), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .done(done), .effAddr(effAddr), .operand(operand)
  );

  function automatic logic [DATA_W-1:0] memVal(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = (32'(a) * 32'd40503) ^ 32'h3C5A;
    return t[DATA_W-1:0];
  endfunction

  // synchronous memory model
  always @(posedge clk) if (memRdEn) memRdData <= memVal(memAddr);

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int expReads(input logic [2:0] m);
    case (m)
      3'd0, 3'd2, 3'd7: return 0;
      3'd3: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic runOne(input logic [2:0] m, input logic [ADDR_W-1:0] f,
                        input logic [1:0] s, input bit scramble, input bit poke);
    logic [ADDR_W-1:0] eEa;
    logic [DATA_W-1:0] eOp;
    int cycles, reads, lat;
    string tag;
    tag = modeTag(m);
    eEa = '0;
    eOp = '0;
    case (m)
      3'd0: eOp = DATA_W'(f);
      3'd1: eEa = f;
      3'd2: eOp = regs[s];
      3'd3: eEa = memVal(f)[ADDR_W-1:0];
      3'd4: eEa = regs[s][ADDR_W-1:0];
      3'd5: eEa = f + indexVal[ADDR_W-1:0];
      3'd6: eEa = baseVal[ADDR_W-1:0] + f;
      default: eOp = tosVal;
    endcase
    if (expReads(m) != 0) eOp = memVal(eEa);
    lat = (expReads(m) == 0) ? 1 : (expReads(m) == 1 ? 3 : 5);

    @(negedge clk);
    mode = m; addrField = f; regSel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    reads = 0;
    if (scramble) begin  // R11: change inputs after acceptance
      for (int i = 0; i < NREG; i++) regs[i] = DATA_W'($urandom);
      indexVal = DATA_W'($urandom);
      baseVal  = DATA_W'($urandom);
      tosVal   = DATA_W'($urandom);
      addrField = ADDR_W'($urandom);
      regSel    = 2'($urandom);
    end
    while (!done && cycles < 20) begin
      if (memRdEn) reads++;
      if (poke) begin
        start = (cycles == 2);
        if (cycles == 2) mode = 3'($urandom);
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check(done === 1'b1 && cycles == lat, {tag, " latency"}, 32'(cycles), 32'(lat));
    check(reads == expReads(m), {tag, " read count"}, 32'(reads), 32'(expReads(m)));
    check(effAddr === eEa, scramble ? {tag, " R11 effAddr"} : {tag, " effAddr"},
          32'(effAddr), 32'(eEa));
    check(operand === eOp, scramble ? {tag, " R11 operand"} : {tag, " operand"},
          32'(operand), 32'(eOp));
    @(negedge clk);
    check(done === 1'b0, "R9 done single cycle", 32'(done), 32'd0);
    if (poke) begin  // R10: stray start caused no second request
      int extra;
      extra = 0;
      for (int k = 0; k < 6; k++) begin
        if (done || memRdEn) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R10 busy start ignored", 32'(extra), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && memRdEn === 1'b0, "R12 in reset",
          {30'd0, done, memRdEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && memRdEn === 1'b0, "R12 after reset",
          {30'd0, done, memRdEn}, 32'd0);

    regs[0] = 16'h1111; regs[1] = 16'h2A05; regs[2] = 16'h0C33; regs[3] = 16'hF7E4;
    indexVal = 16'h0042; baseVal = 16'h0800; tosVal = 16'hBEEF;

    runOne(3'd0, 12'hABC, 2'd0, 0, 0);  // R1
    runOne(3'd1, 12'h123, 2'd0, 0, 0);  // R2
    runOne(3'd2, 12'h000, 2'd1, 0, 0);  // R3
    runOne(3'd3, 12'h456, 2'd0, 0, 0);  // R4
    runOne(3'd4, 12'h000, 2'd3, 0, 0);  // R5
    runOne(3'd5, 12'h300, 2'd0, 0, 0);  // R6
    runOne(3'd6, 12'h010, 2'd0, 0, 0);  // R7
    runOne(3'd7, 12'h000, 2'd0, 0, 0);  // R8

    // wrap corners for R6 and R7
    indexVal = 16'hF002;
    runOne(3'd5, 12'hFFF, 2'd0, 0, 0);
    baseVal = 16'hFFF0;
    runOne(3'd6, 12'h020, 2'd0, 0, 0);

    // R11 scrambled inputs, R10 stray starts
    runOne(3'd2, 12'h000, 2'd2, 1, 0);
    runOne(3'd6, 12'h7FF, 2'd0, 1, 0);
    runOne(3'd3, 12'hFFF, 2'd0, 0, 1);
    runOne(3'd1, 12'h001, 2'd0, 0, 1);

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NREG; i++) regs[i] = DATA_W'($urandom);
      indexVal = DATA_W'($urandom);
      baseVal  = DATA_W'($urandom);
      tosVal   = DATA_W'($urandom);
      runOne(3'($urandom), ADDR_W'($urandom), 2'($urandom),
             ($urandom % 4) == 0, ($urandom % 5) == 0);
    end

    finishRun();
  end

endmodule